// File: doc/BRIEF.md
# Request-Paced Serial Stream Sender

This block streams bytes from a two-half ping-pong buffer to a downstream decoder over a clock-and-data serial link. The link uses SPI mode 0 and has no select line and no return path. The decoder paces the stream with an asynchronous request line. A burst begins either on a rising edge of that line or on a one-cycle start pulse. Once a byte has been shifted out, the block sends the next byte only if the request is still high. Otherwise it parks until the next rising edge.

The buffer holds 512 bytes, split into a lower half (addresses 0 to 255) and an upper half (addresses 256 to 511). A producer writes bytes into a half that is flagged free, then hands it over with a commit strobe. The read pointer walks upward through both halves and wraps back to address 0. When the pointer leaves a half, that half is flagged free again and a one-cycle refill pulse is raised. The sender never transmits from a half that is still flagged free. It waits at the byte boundary until that half is committed.

Top module: `req_spi_streamer`

## Requirements
- R1: The serial clock runs at one sixteenth of the system clock, low for 8 cycles and then high for 8 cycles for each bit, and it rests low when no byte is being sent.
- R2: Each byte leaves most significant bit first, and the data output stays constant while the serial clock is high.
- R3: When the sender is idle, a rising edge on `dreq_i` (after a two-flop synchroniser) or a `start_i` pulse starts a burst.
- R4: When a byte completes, the next byte follows only if the synchronised request is high; a start pulse with the request low sends exactly one byte.
- R5: Bytes are sent in ascending address order; the read pointer advances by one per byte and wraps from 511 to 0, starting at 0 after reset.
- R6: In the cycle after the last byte of a half completes, that half's bit in `half_free_o` (bit 0 = lower half, bit 1 = upper half) goes to 1 and `refill_req_o` is high for exactly that one cycle.
- R7: No bit is sent from a half whose free flag is set; the sender stalls at the byte boundary with the serial clock low until the half is committed.
- R8: A write whose address lies in a half that is not free, or a commit of a half that is not free, has no effect.
- R9: After reset both halves are free, and the serial clock, data output and refill pulse are all low.
- R10: Bit 8 of `wr_addr_i` selects the half, and a commit with `commit_half_i` set to h clears free flag h in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts a burst from idle |
| dreq_i | input | 1 | Asynchronous data request from the decoder |
| wr_en_i | input | 1 | Producer write strobe |
| wr_addr_i | input | 9 | Producer byte address; bit 8 selects the half |
| wr_data_i | input | 8 | Producer write data |
| commit_i | input | 1 | Marks a half as filled |
| commit_half_i | input | 1 | Half selected by the commit |
| sclk_o | output | 1 | Serial clock, mode 0 |
| sdo_o | output | 1 | Serial data, MSB first |
| half_free_o | output | 2 | Per-half free flags |
| refill_req_o | output | 1 | One-cycle pulse when a half is vacated |

## Verification
The assertions assume three things about the inputs. The producer commits a half only after it has finished writing that half. `start_i` is pulsed only while the sender is idle. `dreq_i` holds each level for at least two system clocks, so the synchroniser cannot miss an edge. The stimulus keeps within these limits. It changes every input on the falling clock edge, writes a whole half before committing it, issues its single start pulse before any request activity, and holds each request level for hundreds of cycles. The ignored-write and ignored-commit cases are exercised inside that envelope, against a half that is already committed.

// File: rtl/rss_pkg.sv
package rss_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } rss_state_e;
endpackage

// File: rtl/rss_sync.sv
module rss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rss_pingpong_mem.sv
module rss_pingpong_mem #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            store_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = store_q[raddr_i];
endmodule

// File: rtl/req_spi_streamer.sv
module req_spi_streamer #(
    parameter int DATA_W  = 8,
    parameter int HALF_AW = 8,
    parameter int CLK_DIV = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic               dreq_i,
    input  logic               wr_en_i,
    input  logic [HALF_AW:0]   wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               commit_i,
    input  logic               commit_half_i,
    output logic               sclk_o,
    output logic               sdo_o,
    output logic [1:0]         half_free_o,
    output logic               refill_req_o
);
    import rss_pkg::*;

    localparam int AW       = HALF_AW + 1;
    localparam int CNT_W    = $clog2(CLK_DIV);
    localparam int BIT_W    = $clog2(DATA_W);
    localparam int HALF_DIV = CLK_DIV / 2;

    typedef struct packed {
        rss_state_e         st;
        logic [AW-1:0]      rd;
        logic [CNT_W-1:0]   cnt;
        logic [BIT_W-1:0]   bitn;
        logic [DATA_W-1:0]  sh;
        logic               sclk;
        logic [1:0]         free;
        logic               refill;
    } ctl_t;

    ctl_t q, d;

    logic              req_lvl;
    logic              req_rise;
    logic [DATA_W-1:0] rd_data;
    logic              wr_accept;
    logic              rd_half;

    rss_sync #(.STAGES(2)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (dreq_i),
        .level_o (req_lvl),
        .rise_o  (req_rise)
    );

    assign wr_accept = wr_en_i & q.free[wr_addr_i[AW-1]];

    rss_pingpong_mem #(.AW(AW), .DW(DATA_W)) u_mem (
        .clk_i   (clk_i),
        .we_i    (wr_accept),
        .waddr_i (wr_addr_i),
        .wdata_i (wr_data_i),
        .raddr_i (q.rd),
        .rdata_o (rd_data)
    );

    assign rd_half = q.rd[AW-1];

    always_comb begin
        d        = q;
        d.refill = 1'b0;

        if (commit_i && q.free[commit_half_i]) begin
            d.free[commit_half_i] = 1'b0;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (start_i || req_rise) begin
                    d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!q.free[rd_half]) begin
                    d.st   = ST_SHIFT;
                    d.sh   = rd_data;
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.sclk = 1'b0;
                end
            end
            ST_SHIFT: begin
                d.cnt  = q.cnt + 1'b1;
                d.sclk = (d.cnt >= CNT_W'(HALF_DIV));
                if (q.cnt == CNT_W'(CLK_DIV - 1)) begin
                    d.cnt  = '0;
                    d.sclk = 1'b0;
                    if (q.bitn == BIT_W'(DATA_W - 1)) begin
                        d.rd = q.rd + 1'b1;
                        if (&q.rd[HALF_AW-1:0]) begin
                            d.free[rd_half] = 1'b1;
                            d.refill        = 1'b1;
                        end
                        d.st = req_lvl ? ST_WAIT : ST_IDLE;
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                        d.sh   = {q.sh[DATA_W-2:0], 1'b0};
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st     <= ST_IDLE;
            q.rd     <= '0;
            q.cnt    <= '0;
            q.bitn   <= '0;
            q.sh     <= '0;
            q.sclk   <= 1'b0;
            q.free   <= 2'b11;
            q.refill <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sclk_o       = q.sclk;
    assign sdo_o        = q.sh[DATA_W-1];
    assign half_free_o  = q.free;
    assign refill_req_o = q.refill;
endmodule

// File: rtl/req_spi_streamer_sva.sv
module req_spi_streamer_sva #(
    parameter int CLK_DIV = 16
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       sclk_i,
    input logic       sdo_i,
    input logic [1:0] half_free_i,
    input logic       refill_i,
    input logic       rd_half_i
);
    localparam int HALF_DIV = CLK_DIV / 2;
    localparam int HW       = $clog2(CLK_DIV) + 1;

    logic [HW-1:0] hi_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     hi_cnt_q <= '0;
        else if (sclk_i) hi_cnt_q <= hi_cnt_q + 1'b1;
        else             hi_cnt_q <= '0;
    end

    // R1: high phase never exceeds half the divide ratio
    a_r1_high_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sclk_i |-> (hi_cnt_q < HW'(HALF_DIV)));

    // R2: data held while the serial clock is high
    a_r2_sdo_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sclk_i |-> $stable(sdo_i));

    // R6: refill pulse lasts one cycle
    a_r6_refill_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refill_i |=> !refill_i);

    // R6: a half only becomes free together with a refill pulse
    a_r6_free0_with_refill: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(half_free_i[0]) |-> refill_i);

    a_r6_free1_with_refill: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(half_free_i[1]) |-> refill_i);

    // R7: no clock edge while the half under the read pointer is free
    a_r7_no_send_from_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sclk_i) |-> !half_free_i[rd_half_i]);
endmodule

bind req_spi_streamer req_spi_streamer_sva #(.CLK_DIV(CLK_DIV)) u_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_o),
    .sdo_i       (sdo_o),
    .half_free_i (half_free_o),
    .refill_i    (refill_req_o),
    .rd_half_i   (rd_half)
);

// File: tb/req_spi_streamer_tb_top.sv
module req_spi_streamer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       dreq = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       commit = 1'b0;
    logic       commit_half = 1'b0;
    logic       sclk, sdo, refill;
    logic [1:0] half_free;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    req_spi_streamer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dreq_i(dreq),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .commit_i(commit), .commit_half_i(commit_half),
        .sclk_o(sclk), .sdo_o(sdo), .half_free_o(half_free), .refill_req_o(refill)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0] mdl_mem [512];
    logic [1:0] mdl_free = 2'b11;
    int mdl_rd = 0;
    int bit_i = 0;
    int bytes_sent = 0;
    int since_rise = 0;
    int hi_len = 0;
    logic [7:0] cur_byte = '0;
    logic prev_sclk = 1'b0;
    bit mon_on = 0;

    initial begin
        for (int i = 0; i < 512; i++) mdl_mem[i] = '0;
        forever begin
            @(posedge clk);
            #2;
            if (mon_on) begin
                logic [1:0] nf;
                bit exp_refill;
                nf = mdl_free;
                exp_refill = 0;
                if (commit && mdl_free[commit_half]) nf[commit_half] = 1'b0;   // R8 R10
                if (wr_en && mdl_free[wr_addr[8]]) mdl_mem[wr_addr] = wr_data; // R8
                since_rise++;
                if (sclk) hi_len++;
                if (sclk && !prev_sclk) begin
                    if (bit_i == 0) begin
                        check(!nf[mdl_rd / 256], "R7", nf[mdl_rd / 256], 0);
                        cur_byte = mdl_mem[mdl_rd];
                    end else begin
                        check(since_rise == 16, "R1", since_rise, 16);
                    end
                    check(sdo == cur_byte[7 - bit_i], "R2/R5", sdo, cur_byte[7 - bit_i]);
                    bit_i++;
                    since_rise = 0;
                end
                if (!sclk && prev_sclk) begin
                    check(hi_len == 8, "R1", hi_len, 8);
                    if (bit_i == 8) begin
                        bytes_sent++;
                        if (mdl_rd % 256 == 255) begin
                            exp_refill = 1;
                            nf[mdl_rd / 256] = 1'b1;
                        end
                        mdl_rd = (mdl_rd + 1) % 512;
                        bit_i = 0;
                    end
                end
                if (!sclk) hi_len = 0;
                check(refill == exp_refill, "R6", refill, exp_refill);
                check(half_free == nf, "R6/R8", half_free, nf);
                mdl_free = nf;
                prev_sclk = sclk;
            end
        end
    end

    function automatic logic [7:0] pat(input int a, input int gen);
        return 8'((a * 7 + gen * 91 + 13) ^ (a >> 3));
    endfunction

    task automatic fill_half(input int h, input int gen);
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 9'(h * 256 + a); wr_data = pat(a, gen);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_commit(input int h);
        @(negedge clk);
        commit = 1'b1; commit_half = h[0];
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic wait_bytes(input int n);
        while (bytes_sent < n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        check(sclk == 1'b0, "R9", sclk, 0);
        check(sdo == 1'b0, "R9", sdo, 0);
        check(refill == 1'b0, "R9", refill, 0);
        check(half_free == 2'b11, "R9", half_free, 3);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1;

        // R10: lower and upper halves filled by address bit 8
        fill_half(0, 1);
        do_commit(0);
        check(half_free == 2'b10, "R10", half_free, 2);
        // R8: write into committed half ignored (checked when byte 10 leaves)
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'd10; wr_data = ~pat(10, 1);
        @(negedge clk);
        wr_en = 1'b0;
        fill_half(1, 2);
        do_commit(1);
        // R8: commit of an already committed half has no effect
        do_commit(1);
        check(half_free == 2'b00, "R8", half_free, 0);

        // R4: start pulse with request low sends exactly one byte
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (400) @(negedge clk);
        check(bytes_sent == 1, "R4", bytes_sent, 1);
        check(sclk == 1'b0, "R1", sclk, 0);

        // R3: rising request edge starts a burst; R4: one more byte after drop
        dreq = 1'b1;
        wait_bytes(200);
        dreq = 1'b0;
        repeat (400) @(negedge clk);
        check(bytes_sent == 201, "R4", bytes_sent, 201);

        // R6: cross into upper half, lower half freed and refilled
        dreq = 1'b1;
        wait_bytes(257);
        check(half_free == 2'b01, "R6", half_free, 1);
        // R8: write into the half being read is ignored
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'd300; wr_data = ~pat(44, 2);
        @(negedge clk);
        wr_en = 1'b0;
        fill_half(0, 3);
        do_commit(0);

        // R5: wrap from 511 to 0, then stall (R7) when upper half is not refilled
        wait_bytes(513);
        check(half_free == 2'b10, "R5", half_free, 2);
        wait_bytes(768);
        repeat (600) @(negedge clk);
        check(bytes_sent == 768, "R7", bytes_sent, 768);
        check(sclk == 1'b0, "R7", sclk, 0);
        fill_half(1, 4);
        do_commit(1);
        wait_bytes(770);
        dreq = 1'b0;
        repeat (400) @(negedge clk);
        check(bytes_sent == 771, "R4", bytes_sent, 771);

        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d bytes", bytes_sent, 771);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule